// File: doc/BRIEF.md
# Clocked Serial Receive Engine

This block receives a synchronous serial bit stream and turns it into bytes. A serial clock marks each bit. That clock either comes from outside the chip or is made inside the block by a programmable divider. Software uses three control inputs: a start level that enables reception, an inhibit level that aborts it, and a source select that picks the internal or the external serial clock. Bits arrive least-significant first. After every eighth bit the assembled word moves into a holding buffer. At that moment the block raises a one-cycle interrupt pulse and sets a buffer-full level.

With the internal clock, the engine stops the serial clock once a word lands in the buffer. The clock stays stopped until software reads the buffer, so no data is lost. With the external clock, shifting keeps following the remote clock. A word that completes before the previous one has been read overwrites the buffer and sets a sticky overrun flag.

There are two ways to stop. Dropping the start level is a graceful stop: the word in flight still completes and is buffered. Raising the inhibit level aborts at once and throws the partial word away. Changing the clock source empties the buffer.

The controller has four named states:
- IDLE: not receiving.
- RUN: shifting bits.
- FINISH: shifting out the last word after a graceful stop.
- STALL: internal clock held while the buffer waits to be read.

The state transitions are:
- IDLE to RUN on start. If the clock is internal and the buffer is full, IDLE goes to STALL instead.
- RUN to FINISH when start drops mid-word.
- RUN to STALL on word completion with the internal clock.
- RUN to IDLE on word completion with start low.
- FINISH to IDLE on word completion.
- STALL to RUN on a buffer read.
- STALL to IDLE when start drops.
- Any state to IDLE on inhibit or on a clock-source change.

Top module: `ser_rx_engine`

## Requirements
- R1: Each serial bit lands one position further up the word: the first bit received becomes bit 0 and the eighth becomes bit 7 of `rx_data`.
- R2: When the eighth bit is taken, `rx_data` is loaded, `rx_irq` pulses high for exactly one system cycle, and `rx_full` rises and stays high until `rd_strobe` is pulsed.
- R3: While idle, `cfg_start` high with `cfg_inhibit` low makes `busy` rise within two cycles. With `cfg_inhibit` high, `cfg_start` has no effect.
- R4: With `cfg_ext_clk` = 0, `sck_out` idles high. While receiving it toggles with a half period of `cfg_div`+1 system cycles, and a bit is taken on each rising edge.
- R5: With the internal clock, once a word is buffered `sck_out` stays high and no bits are taken until `rd_strobe`. After the read, clocking resumes if `cfg_start` is still high.
- R6: With `cfg_ext_clk` = 1, bits are taken on rising edges of `ext_sck` after a two-stage synchronizer, with no stall while the buffer is full.
- R7: If a word completes while `rx_full` is high and no read occurs in that cycle, the new word overwrites `rx_data` and `rx_overrun` becomes 1. `rx_overrun` stays 1 until reset or a clock-source change.
- R8: Clearing `cfg_start` mid-word lets that word finish and be buffered, and then `busy` falls to 0.
- R9: `cfg_inhibit` high while busy makes `busy` 0 on the next cycle. The partial word is discarded, with no interrupt and no change to `rx_data`.
- R10: A change of `cfg_ext_clk` clears `rx_data` to 0 and clears `rx_full` and `rx_overrun`.
- R11: After reset, `busy`, `rx_full`, `rx_irq` and `rx_overrun` are 0, `rx_data` is 0, and `sck_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_start | input | 1 | Receive enable level |
| cfg_inhibit | input | 1 | Immediate abort level |
| cfg_ext_clk | input | 1 | 1 = external serial clock, 0 = internal divider |
| cfg_div | input | DIV_W | Internal clock half period minus one, in system cycles |
| ext_sck | input | 1 | External serial clock |
| ext_sdi | input | 1 | Serial data input |
| rd_strobe | input | 1 | One-cycle buffer read pulse |
| sck_out | output | 1 | Internally generated serial clock, idle high |
| rx_data | output | WORD_W | Received word buffer |
| rx_full | output | 1 | Buffer holds an unread word |
| rx_irq | output | 1 | One-cycle buffer-full interrupt |
| rx_overrun | output | 1 | Sticky overwrite flag |
| busy | output | 1 | Reception in progress |

## Verification
The bench builds the block with its defaults: an 8-bit word, a 4-bit divider field and two synchronizer stages. At run time it drives `cfg_div` = 3, so each internal half period lasts four cycles. That is long enough for data changed on a falling edge to pass the synchronizer before the next rising edge, and short enough for several dozen words plus the stall, abort and overrun scenarios to fit in a few thousand cycles. The external clock is held six cycles per phase, which keeps every edge clear of the synchronizer latency.

// File: rtl/ser_rx_pkg.sv
package ser_rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2,
        ST_STALL  = 2'd3
    } rx_state_t;
endpackage

// File: rtl/ser_rx_sync.sv
module ser_rx_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= {STAGES{RST_VAL}};
        else        pipe <= {pipe[STAGES-2:0], d_in};
    end

    assign q_out = pipe[STAGES-1];
endmodule

// File: rtl/ser_rx_clkgen.sv
module ser_rx_clkgen #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             sck_o,
    output logic             rise_o
);
    logic [DIV_W-1:0] cnt;
    logic             sck_q;
    logic             term;

    assign term = (cnt == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            sck_q <= 1'b1;
        end else if (!en) begin
            cnt   <= '0;
            sck_q <= 1'b1;
        end else if (term) begin
            cnt   <= '0;
            sck_q <= ~sck_q;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

    assign sck_o  = sck_q;
    assign rise_o = en && term && !sck_q;
endmodule

// File: rtl/ser_rx_shift.sv
module ser_rx_shift #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word_o,
    output logic              done_o
);
    localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [WORD_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;
    logic              last;

    assign last   = (cnt == LAST);
    assign word_o = {bit_in, sh[WORD_W-1:1]};
    assign done_o = sample && last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh  <= '0;
            cnt <= '0;
        end else if (clear) begin
            sh  <= '0;
            cnt <= '0;
        end else if (sample) begin
            sh  <= word_o;
            cnt <= last ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ser_rx_engine.sv
module ser_rx_engine
    import ser_rx_pkg::*;
#(
    parameter int WORD_W      = 8,
    parameter int DIV_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_start,
    input  logic              cfg_inhibit,
    input  logic              cfg_ext_clk,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              ext_sck,
    input  logic              ext_sdi,
    input  logic              rd_strobe,
    output logic              sck_out,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_full,
    output logic              rx_irq,
    output logic              rx_overrun,
    output logic              busy
);
    rx_state_t         state, state_nxt;
    logic              sck_s, sdi_s, sck_prev, ext_rise;
    logic              mode_q, mode_chg;
    logic              shifting, clk_en, int_rise, sample, shift_clear;
    logic              done;
    logic [WORD_W-1:0] word;

    ser_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sck (
        .clk(clk), .rst_n(rst_n), .d_in(ext_sck), .q_out(sck_s));
    ser_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
        .clk(clk), .rst_n(rst_n), .d_in(ext_sdi), .q_out(sdi_s));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_prev <= 1'b1;
            mode_q   <= 1'b0;
        end else begin
            sck_prev <= sck_s;
            mode_q   <= cfg_ext_clk;
        end
    end

    assign ext_rise = sck_s && !sck_prev;
    assign mode_chg = (cfg_ext_clk != mode_q);
    assign shifting = (state == ST_RUN) || (state == ST_FINISH);
    assign clk_en   = shifting && !cfg_ext_clk && !mode_chg;

    ser_rx_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .en(clk_en), .div(cfg_div),
        .sck_o(sck_out), .rise_o(int_rise));

    assign sample = shifting && !mode_chg && !cfg_inhibit &&
                    (cfg_ext_clk ? ext_rise : int_rise);
    assign shift_clear = (state == ST_IDLE) || cfg_inhibit || mode_chg;

    ser_rx_shift #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clear(shift_clear), .sample(sample),
        .bit_in(sdi_s), .word_o(word), .done_o(done));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        if (mode_chg || cfg_inhibit) begin
            state_nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (cfg_start)
                        state_nxt = (!cfg_ext_clk && rx_full) ? ST_STALL : ST_RUN;
                end
                ST_RUN: begin
                    if (done) begin
                        if (!cfg_start)       state_nxt = ST_IDLE;
                        else if (!cfg_ext_clk) state_nxt = ST_STALL;
                        else                  state_nxt = ST_RUN;
                    end else if (!cfg_start) begin
                        state_nxt = ST_FINISH;
                    end
                end
                ST_FINISH: begin
                    if (done) state_nxt = ST_IDLE;
                end
                ST_STALL: begin
                    if (!cfg_start)     state_nxt = ST_IDLE;
                    else if (rd_strobe) state_nxt = ST_RUN;
                end
                default: state_nxt = ST_IDLE;
            endcase
        end
    end

    // output / buffer process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data    <= '0;
            rx_full    <= 1'b0;
            rx_irq     <= 1'b0;
            rx_overrun <= 1'b0;
        end else begin
            rx_irq <= 1'b0;
            if (mode_chg) begin
                rx_data    <= '0;
                rx_full    <= 1'b0;
                rx_overrun <= 1'b0;
            end else if (done) begin
                rx_data <= word;
                rx_full <= 1'b1;
                rx_irq  <= 1'b1;
                if (rx_full && !rd_strobe) rx_overrun <= 1'b1;
            end else if (rd_strobe) begin
                rx_full <= 1'b0;
            end
        end
    end

    assign busy = (state != ST_IDLE);
endmodule

// File: rtl/ser_rx_engine_chk.sv
module ser_rx_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_inhibit,
    input logic cfg_ext_clk,
    input logic sck_out,
    input logic rx_full,
    input logic rx_irq,
    input logic rx_overrun,
    input logic busy
);
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);  // R2
    AST_IRQ_WITH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rx_full);  // R2
    AST_IRQ_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> $past(busy));  // R8
    AST_IDLE_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> sck_out);  // R4
    AST_STALL_HOLDS_SCK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cfg_ext_clk && rx_full) |-> sck_out);  // R5
    AST_ABORT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_inhibit && busy) |=> !busy);  // R9
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overrun && $stable(cfg_ext_clk)) |=> rx_overrun);  // R7
endmodule

bind ser_rx_engine ser_rx_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_inhibit(cfg_inhibit),
    .cfg_ext_clk(cfg_ext_clk), .sck_out(sck_out), .rx_full(rx_full),
    .rx_irq(rx_irq), .rx_overrun(rx_overrun), .busy(busy));

// File: tb/tb_ser_rx_engine.sv
module tb_ser_rx_engine;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_VAL    = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_start = 1'b0, cfg_inhibit = 1'b0, cfg_ext_clk = 1'b0;
    logic [3:0] cfg_div = 4'(DIV_VAL);
    logic       ext_sck = 1'b1, ext_sdi = 1'b0, rd_strobe = 1'b0;
    logic       sck_out, rx_full, rx_irq, rx_overrun, busy;
    logic [7:0] rx_data;

    int total = 0;
    int bad = 0;
    int irq_cnt = 0;
    bit finished = 0;

    ser_rx_engine dut (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_inhibit(cfg_inhibit),
        .cfg_ext_clk(cfg_ext_clk), .cfg_div(cfg_div), .ext_sck(ext_sck),
        .ext_sdi(ext_sdi), .rd_strobe(rd_strobe), .sck_out(sck_out),
        .rx_data(rx_data), .rx_full(rx_full), .rx_irq(rx_irq),
        .rx_overrun(rx_overrun), .busy(busy));

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (rx_irq) irq_cnt++;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_buf();
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
    endtask

    // internal clock word: bit i placed on the line after each falling edge
    task automatic send_int(input logic [7:0] b, input bit via_read, input int drop_at);
        ext_sdi = b[0];
        if (via_read) begin
            @(negedge clk); rd_strobe = 1'b1;
            @(negedge clk); rd_strobe = 1'b0;
        end else begin
            cfg_start = 1'b1;
        end
        @(negedge sck_out);
        for (int i = 1; i < 8; i++) begin
            @(posedge sck_out);
            #1;
            if (i == drop_at) cfg_start = 1'b0;
            @(negedge sck_out);
            #1 ext_sdi = b[i];
        end
        @(posedge sck_out);
        repeat (3) @(negedge clk);
    endtask

    task automatic send_ext(input logic [7:0] b, input int drop_at);
        for (int i = 0; i < 8; i++) begin
            ext_sdi = b[i];
            ext_sck = 1'b0;
            repeat (6) @(negedge clk);
            if (i == drop_at) cfg_start = 1'b0;
            ext_sck = 1'b1;
            repeat (6) @(negedge clk);
        end
    endtask

    // [12]=external clock, [11:8]=bit index where start is dropped, [7:0]=word
    localparam logic [12:0] VEC [6] = '{
        {1'b0, 4'd3, 8'hA5},
        {1'b0, 4'd7, 8'h01},
        {1'b1, 4'd2, 8'h80},
        {1'b1, 4'd5, 8'h3C},
        {1'b0, 4'd1, 8'hFF},
        {1'b1, 4'd7, 8'h6D}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int base;
        int lows;
        logic [7:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(!busy && !rx_full && !rx_irq && !rx_overrun, "R11 flags", {busy, rx_full, rx_irq, rx_overrun}, 0);
        chk(rx_data == 8'h00, "R11 data", rx_data, 0);
        chk(sck_out == 1'b1, "R11 sck idle", sck_out, 1);

        // table: R1 / R2 / R8 in both clock modes
        foreach (VEC[k]) begin
            cfg_ext_clk = VEC[k][12];
            repeat (4) @(negedge clk);
            base = irq_cnt;
            if (VEC[k][12]) begin
                cfg_start = 1'b1;
                send_ext(VEC[k][7:0], int'(VEC[k][11:8]));
            end else begin
                send_int(VEC[k][7:0], 1'b0, int'(VEC[k][11:8]));
            end
            chk(rx_data == VEC[k][7:0], "R1 word", rx_data, VEC[k][7:0]);
            chk(irq_cnt == base + 1, "R2 single irq", irq_cnt, base + 1);
            chk(rx_full, "R2 full set", rx_full, 1);
            chk(!busy, "R8 busy after stop", busy, 0);
            read_buf();
            chk(!rx_full, "R2 full cleared by read", rx_full, 0);
        end

        // R4 half period and R9 abort, internal clock
        cfg_ext_clk = 1'b0;
        repeat (4) @(negedge clk);
        held = rx_data;
        base = irq_cnt;
        ext_sdi = 1'b1;
        cfg_start = 1'b1;
        @(negedge sck_out);
        lows = 0;
        @(negedge clk);
        while (!sck_out) begin lows++; @(negedge clk); end
        chk(lows == DIV_VAL + 1, "R4 low half period", lows, DIV_VAL + 1);
        lows = 0;
        while (sck_out) begin lows++; @(negedge clk); end
        chk(lows == DIV_VAL + 1, "R4 high half period", lows, DIV_VAL + 1);
        repeat (12) @(negedge clk);
        cfg_inhibit = 1'b1;
        @(negedge clk);
        chk(!busy, "R9 busy drops next cycle", busy, 0);
        repeat (3) @(negedge clk);
        chk(sck_out, "R9 clock idles after abort", sck_out, 1);
        chk(irq_cnt == base && rx_data == held, "R9 no irq no data change", {irq_cnt[15:0], 8'h0, rx_data}, {base[15:0], 8'h0, held});
        cfg_start = 1'b0;
        cfg_inhibit = 1'b0;
        repeat (3) @(negedge clk);

        // R3: inhibit blocks start
        cfg_inhibit = 1'b1;
        cfg_start = 1'b1;
        repeat (5) @(negedge clk);
        chk(!busy, "R3 inhibit blocks start", busy, 0);
        cfg_inhibit = 1'b0;
        repeat (2) @(negedge clk);
        chk(busy, "R3 start takes effect", busy, 1);
        cfg_inhibit = 1'b1;
        cfg_start = 1'b0;
        repeat (2) @(negedge clk);
        cfg_inhibit = 1'b0;
        repeat (2) @(negedge clk);

        // R5 stall in internal mode
        base = irq_cnt;
        send_int(8'h96, 1'b0, 8);
        chk(rx_data == 8'h96 && busy && rx_full, "R5 word held in stall", {busy, rx_full, rx_data}, {2'b11, 8'h96});
        lows = 0;
        for (int i = 0; i < 60; i++) begin
            ext_sdi = i[0];
            @(negedge clk);
            if (!sck_out) lows++;
        end
        chk(lows == 0, "R5 clock held high", lows, 0);
        chk(irq_cnt == base + 1 && rx_data == 8'h96 && rx_full, "R5 nothing taken in stall", {irq_cnt[15:0], rx_data}, {16'(base + 1), 8'h96});
        send_int(8'h5A, 1'b1, 4);
        chk(rx_data == 8'h5A && !busy, "R5 resumes after read", {busy, rx_data}, {1'b0, 8'h5A});
        chk(!rx_overrun, "R7 no overrun on internal path", rx_overrun, 0);
        read_buf();

        // R6 / R7 external mode, no stall, overrun
        cfg_ext_clk = 1'b1;
        repeat (4) @(negedge clk);
        cfg_start = 1'b1;
        send_ext(8'h11, 8);
        chk(rx_data == 8'h11 && rx_full && busy && sck_out, "R6 external word", {busy, rx_full, sck_out, rx_data}, {3'b111, 8'h11});
        send_ext(8'hEE, 8);
        chk(rx_data == 8'hEE, "R7 overwrite", rx_data, 8'hEE);
        chk(rx_overrun, "R7 overrun set", rx_overrun, 1);
        read_buf();
        repeat (5) @(negedge clk);
        chk(rx_overrun && !rx_full, "R7 overrun sticky", {rx_overrun, rx_full}, 2'b10);

        // R9 external abort discards partial bits
        for (int i = 0; i < 3; i++) begin
            ext_sdi = 1'b1; ext_sck = 1'b0;
            repeat (6) @(negedge clk);
            ext_sck = 1'b1;
            repeat (6) @(negedge clk);
        end
        cfg_inhibit = 1'b1;
        @(negedge clk);
        chk(!busy, "R9 external abort", busy, 0);
        cfg_inhibit = 1'b0;
        @(negedge clk);
        send_ext(8'hC3, 8);
        chk(rx_data == 8'hC3, "R9 partial bits discarded", rx_data, 8'hC3);
        cfg_inhibit = 1'b1;
        cfg_start = 1'b0;
        repeat (2) @(negedge clk);
        cfg_inhibit = 1'b0;

        // R10 mode change clears buffer
        cfg_ext_clk = 1'b0;
        repeat (3) @(negedge clk);
        chk(rx_data == 8'h00 && !rx_full && !rx_overrun, "R10 cleared on mode change", {rx_overrun, rx_full, rx_data}, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule